// File: doc/BRIEF.md
# Streaming Factory-Program Controller

This block is the device-side control for a fast bulk programming mode of a flash-like array. The host opens the mode once per block with a two-write command pair at the block start address. From then on it only streams plain data writes into an internal write buffer. Each buffer is committed to consecutive array words, and the array region then advances by one buffer length without any new address setup from the host.

A status byte tells the host when it may send the next buffer. Bit 0 is high while the buffer is being committed. Bit 7 is high whenever the controller is outside the streaming mode. Error bits report a broken or misaligned opening sequence, a low programming voltage, and a failed per-word verify.

The array model behaves like flash. A program operation can only clear bits. Each word is verified against its intended data in the same step that writes it, after a fixed latency. The host leaves the mode by writing all-ones data to any address outside the block being programmed. A half-filled buffer is committed before the controller reports ready again.

Top module: `fpgm_ctrl`

## Requirements
- R1: After reset the status byte reads 80h (bit 7 ready, all other bits 0), and every array word reads all ones.
- R2: Writing 80h and then D0h, both at the same buffer-aligned address and with `vpp_ok` high, enters the mode. The status then reads 00h, and the containing block (BLOCK_WORDS words, aligned to BLOCK_WORDS) becomes the target block.
- R3: A confirm at a start address whose low log2(BUF_WORDS) bits are not zero is refused. Bits 5 and 4 are set, bit 7 stays 1 (status B0h), and the mode is not entered.
- R4: After 80h, a second write that is not D0h, or that goes to a different address, is refused with status B0h. Error bits 5 and 4 then stay set until reset.
- R5: A confirm with `vpp_ok` low is refused, and bits 4 and 3 are set (status 98h).
- R6: In the mode, each write inside the target block stores its data as the next buffer word in arrival order, whatever its address offset. The write that fills word BUF_WORDS-1 sets status bit 0 in the next cycle. The buffer is then programmed into the current region, starting at its base, and bit 0 returns to 0.
- R7: Data writes made while status bit 0 is 1 are ignored. They reach neither the array nor the next buffer.
- R8: Each committed full buffer advances the region by BUF_WORDS. The next buffer lands at the following addresses, and the host gives no address setup.
- R9: Writing FFFFh (all ones) to an address outside the target block leaves the mode. With an empty buffer the status returns to 80h at once. With k pending words, bit 0 goes high, the k words are programmed, and the status then returns to 80h. Any other data written outside the block is ignored.
- R10: If a word's verify fails, meaning the data has a 1 where the cell already holds 0, bit 4 is set. The mode ends with status 90h, and later words of that buffer are left untouched.
- R11: Committing the buffer that fills the last region of the block ends the mode by itself, and the status returns to 80h.
- R12: Programming stores the bitwise AND of the old cell and the data. This also holds for the failing word of R10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Host word address |
| wr_data | input | DATA_W | Host write data (command or buffer data) |
| vpp_ok | input | 1 | Programming voltage is adequate |
| status | output | 8 | Status byte: 7 ready, 5 sequence error, 4 program error, 3 voltage error, 0 buffer busy |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array word at `rd_addr` |

## Verification
On every cycle the assertions check the status relations. The busy bit never shows together with ready, and it rises only in the cycle after a host write. The error bits are sticky, and a verify failure returns the controller to ready. Where the data ends up can only be shown by the bench's scenarios, which read the whole array back against an arithmetic model. These scenarios cover arrival-order buffering, region advance, partial commit on exit, writes dropped while busy, the AND behaviour of programming, and the early stop on a verify failure.

// File: rtl/fpgm_pkg.sv
package fpgm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_FILL,
        PH_PROG
    } phase_e;

    localparam logic [7:0] CMD_OPEN    = 8'h80;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;

    typedef struct packed {
        logic ready;
        logic seq_err;
        logic prog_err;
        logic vpp_err;
        logic buf_busy;
    } status_t;

    function automatic logic [7:0] pack_status(status_t s);
        return {s.ready, 1'b0, s.seq_err, s.prog_err, s.vpp_err, 2'b00, s.buf_busy};
    endfunction

endpackage

// File: rtl/fpgm_wbuf.sv
module fpgm_wbuf #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 512,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (wr && count < CNT_W'(DEPTH)) begin
            count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!clr && wr && count < CNT_W'(DEPTH)) begin
            mem[count[IDX_W-1:0]] <= wdata;
        end
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/fpgm_array.sv
module fpgm_array #(
    parameter int DATA_W   = 16,
    parameter int ADDR_W   = 11,
    parameter int PROG_LAT = 4,
    localparam int WORDS   = 1 << ADDR_W,
    localparam int LAT_W   = $clog2(PROG_LAT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              done,
    output logic              ok,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [WORDS];
    logic              busy;
    logic [LAT_W-1:0]  lat_cnt;
    logic [ADDR_W-1:0] a_q;
    logic [DATA_W-1:0] d_q;
    logic              cell_match;

    // a word verifies only if it needs no bit raised from 0 to 1
    assign cell_match = ((~mem[a_q]) & d_q) == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            ok      <= 1'b0;
            lat_cnt <= '0;
            a_q     <= '0;
            d_q     <= '0;
            for (int i = 0; i < WORDS; i++) mem[i] <= '1;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                busy    <= 1'b1;
                lat_cnt <= LAT_W'(PROG_LAT - 1);
                a_q     <= addr;
                d_q     <= data;
            end else if (busy) begin
                if (lat_cnt == '0) begin
                    busy     <= 1'b0;
                    done     <= 1'b1;
                    ok       <= cell_match;
                    mem[a_q] <= mem[a_q] & d_q;
                end else begin
                    lat_cnt <= lat_cnt - 1'b1;
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/fpgm_seq.sv
module fpgm_seq
    import fpgm_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 11,
    parameter int BUF_WORDS   = 512,
    parameter int BLOCK_WORDS = 1024,
    localparam int BUF_W      = $clog2(BUF_WORDS),
    localparam int BLK_W      = $clog2(BLOCK_WORDS),
    localparam int CNT_W      = $clog2(BUF_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              vpp_ok,
    input  logic [CNT_W-1:0]  buf_count,
    output logic              buf_wr,
    output logic              buf_clr,
    output logic [BUF_W-1:0]  buf_idx,
    output logic              arr_start,
    output logic [ADDR_W-1:0] arr_addr,
    input  logic              arr_done,
    input  logic              arr_ok,
    output logic [7:0]        status
);
    phase_e            phase;
    status_t           sr;
    logic [ADDR_W-1:0] open_addr;
    logic [ADDR_W-1:0] region;
    logic [CNT_W-1:0]  prog_idx;
    logic [CNT_W-1:0]  prog_total;
    logic              in_flight;
    logic              exit_pend;

    logic              in_blk, all_ones, is_open, is_confirm, aligned;
    logic              confirm_ok, last_word, blk_end;
    logic [ADDR_W-1:0] next_region;

    assign in_blk      = wr_addr[ADDR_W-1:BLK_W] == region[ADDR_W-1:BLK_W];
    assign all_ones    = &wr_data;
    assign is_open     = wr_data == DATA_W'(CMD_OPEN);
    assign is_confirm  = wr_data == DATA_W'(CMD_CONFIRM);
    assign aligned     = wr_addr[BUF_W-1:0] == '0;
    assign confirm_ok  = (phase == PH_SETUP) && wr_en && is_confirm
                         && (wr_addr == open_addr) && aligned && vpp_ok;
    assign last_word   = prog_idx == prog_total - 1'b1;
    assign next_region = region + ADDR_W'(BUF_WORDS);
    assign blk_end     = next_region[BLK_W-1:0] == '0;

    assign buf_wr    = (phase == PH_FILL) && wr_en && in_blk;
    assign buf_clr   = confirm_ok
                       || ((phase == PH_PROG) && arr_done && (!arr_ok || last_word));
    assign arr_start = (phase == PH_PROG) && !in_flight;
    assign arr_addr  = region + ADDR_W'(prog_idx);
    assign buf_idx   = prog_idx[BUF_W-1:0];
    assign status    = pack_status(sr);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            sr         <= '{ready: 1'b1, default: 1'b0};
            open_addr  <= '0;
            region     <= '0;
            prog_idx   <= '0;
            prog_total <= '0;
            in_flight  <= 1'b0;
            exit_pend  <= 1'b0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (wr_en && is_open) begin
                        phase     <= PH_SETUP;
                        open_addr <= wr_addr;
                    end
                end
                PH_SETUP: begin
                    if (wr_en) begin
                        if (!(is_confirm && wr_addr == open_addr) || !aligned) begin
                            sr.seq_err  <= 1'b1;
                            sr.prog_err <= 1'b1;
                            phase       <= PH_IDLE;
                        end else if (!vpp_ok) begin
                            sr.prog_err <= 1'b1;
                            sr.vpp_err  <= 1'b1;
                            phase       <= PH_IDLE;
                        end else begin
                            phase       <= PH_FILL;
                            region      <= wr_addr;
                            sr.ready    <= 1'b0;
                            sr.buf_busy <= 1'b0;
                            exit_pend   <= 1'b0;
                        end
                    end
                end
                PH_FILL: begin
                    if (wr_en) begin
                        if (in_blk) begin
                            if (buf_count == CNT_W'(BUF_WORDS - 1)) begin
                                phase       <= PH_PROG;
                                prog_total  <= CNT_W'(BUF_WORDS);
                                prog_idx    <= '0;
                                sr.buf_busy <= 1'b1;
                            end
                        end else if (all_ones) begin
                            if (buf_count == '0) begin
                                phase    <= PH_IDLE;
                                sr.ready <= 1'b1;
                            end else begin
                                phase       <= PH_PROG;
                                prog_total  <= buf_count;
                                prog_idx    <= '0;
                                sr.buf_busy <= 1'b1;
                                exit_pend   <= 1'b1;
                            end
                        end
                    end
                end
                PH_PROG: begin
                    if (arr_start) in_flight <= 1'b1;
                    if (arr_done) begin
                        in_flight <= 1'b0;
                        if (!arr_ok) begin
                            phase       <= PH_IDLE;
                            sr.prog_err <= 1'b1;
                            sr.ready    <= 1'b1;
                            sr.buf_busy <= 1'b0;
                            exit_pend   <= 1'b0;
                        end else if (last_word) begin
                            sr.buf_busy <= 1'b0;
                            region      <= next_region;
                            if (exit_pend || blk_end) begin
                                phase     <= PH_IDLE;
                                sr.ready  <= 1'b1;
                                exit_pend <= 1'b0;
                            end else begin
                                phase <= PH_FILL;
                            end
                        end else begin
                            prog_idx <= prog_idx + 1'b1;
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fpgm_ctrl.sv
module fpgm_ctrl #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 11,
    parameter int BUF_WORDS   = 512,
    parameter int BLOCK_WORDS = 1024,
    parameter int PROG_LAT    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              vpp_ok,
    output logic [7:0]        status,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int BUF_W = $clog2(BUF_WORDS);
    localparam int CNT_W = $clog2(BUF_WORDS + 1);

    logic [CNT_W-1:0]  buf_count;
    logic              buf_wr, buf_clr;
    logic [BUF_W-1:0]  buf_idx;
    logic [DATA_W-1:0] buf_q;
    logic              arr_start, arr_done, arr_ok;
    logic [ADDR_W-1:0] arr_addr;

    fpgm_seq #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W),
        .BUF_WORDS(BUF_WORDS), .BLOCK_WORDS(BLOCK_WORDS)
    ) u_seq (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .vpp_ok(vpp_ok),
        .buf_count(buf_count), .buf_wr(buf_wr), .buf_clr(buf_clr), .buf_idx(buf_idx),
        .arr_start(arr_start), .arr_addr(arr_addr),
        .arr_done(arr_done), .arr_ok(arr_ok),
        .status(status)
    );

    fpgm_wbuf #(.DATA_W(DATA_W), .DEPTH(BUF_WORDS)) u_wbuf (
        .clk(clk), .rst(rst),
        .wr(buf_wr), .wdata(wr_data), .clr(buf_clr),
        .rd_idx(buf_idx), .rd_data(buf_q), .count(buf_count)
    );

    fpgm_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PROG_LAT(PROG_LAT)) u_array (
        .clk(clk), .rst(rst),
        .start(arr_start), .addr(arr_addr), .data(buf_q),
        .done(arr_done), .ok(arr_ok),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: rtl/fpgm_ctrl_chk.sv
module fpgm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] status
);
    // R1: status leaves reset as ready with no error and no busy
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> status == 8'h80);

    // R6: busy is a mode-only condition and never coexists with ready
    assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (rst)
        status[0] |-> !status[7]);

    // R7: busy rises only after a host write filled or closed the buffer
    assert_busy_from_write_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> $past(wr_en));

    // R4: sequence error is sticky
    assert_seq_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        $past(status[5]) |-> status[5]);

    // R10: program error is sticky, and its arrival leaves the mode
    assert_prog_err_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        $past(status[4]) |-> status[4]);

    assert_fault_ends_mode_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(status[4]) |-> status[7]);

    // R9: returning to ready always comes with the buffer idle
    assert_exit_idle_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(status[7]) |-> !status[0]);
endmodule

bind fpgm_ctrl fpgm_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .status(status)
);

// File: tb/test_fpgm_ctrl.sv
`timescale 1ns/1ps
module test_fpgm_ctrl;
    localparam int DW = 16, AW = 6, BUFW = 8, BLKW = 32, LAT = 2, NW = 64;

    logic          clk = 1'b0, rst = 1'b1, wr_en = 1'b0, vpp_ok = 1'b1;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic [7:0]    status;

    fpgm_ctrl #(.DATA_W(DW), .ADDR_W(AW), .BUF_WORDS(BUFW),
                .BLOCK_WORDS(BLKW), .PROG_LAT(LAT)) i_fpgm_ctrl (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .vpp_ok(vpp_ok), .status(status), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [DW-1:0] model [NW];
    logic [DW-1:0] bufd [BUFW];

    always @(posedge clk) cyc++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NW; i++) model[i] = '1;
        @(negedge clk);
    endtask

    task automatic wait_free();
        int t = 0;
        while (status[0] && t < 2000) begin
            @(negedge clk);
            t++;
        end
        if (t >= 2000) chk("R6 busy timeout", 1, 0);
    endtask

    task automatic check_array(input string req);
        for (int i = 0; i < NW; i++) begin
            rd_addr = AW'(i);
            #0.5;
            chk(req, rd_data, model[i]);
        end
    endtask

    // flash-style model: AND into the cell, stop at the first failing verify
    function automatic bit model_prog(input int base, input int n);
        for (int i = 0; i < n; i++) begin
            bit bad;
            bad = ((~model[base + i]) & bufd[i]) != '0;
            model[base + i] = model[base + i] & bufd[i];
            if (bad) return 1'b1;
        end
        return 1'b0;
    endfunction

    initial begin
        wait (cyc >= 50000);
        chk("watchdog", 1, 0);
        summary();
    end

    initial begin
        bit f;
        do_reset();
        chk("R1 reset status", status, 8'h80);
        check_array("R1 erased array");

        // R3: misaligned start address
        wr(6'd3, 16'h0080); wr(6'd3, 16'h00D0);
        chk("R3 misaligned", status, 8'hB0);
        do_reset();

        // R4: wrong confirm code, then confirm at another address
        wr(6'd0, 16'h0080); wr(6'd0, 16'h0040);
        chk("R4 bad code", status, 8'hB0);
        wr(6'd8, 16'h1234);
        chk("R4 sticky", status, 8'hB0);
        do_reset();
        wr(6'd0, 16'h0080); wr(6'd8, 16'h00D0);
        chk("R4 addr differs", status, 8'hB0);
        do_reset();

        // R5: low voltage
        vpp_ok = 1'b0;
        wr(6'd0, 16'h0080); wr(6'd0, 16'h00D0);
        chk("R5 vpp low", status, 8'h98);
        vpp_ok = 1'b1;
        do_reset();

        // R2, R6, R7: open block 1, scattered addresses fill in arrival order
        wr(6'd32, 16'h0080); wr(6'd32, 16'h00D0);
        chk("R2 mode entered", status, 8'h00);
        for (int i = 0; i < BUFW; i++) begin
            bufd[i] = 16'hA000 ^ 16'(i * 16'h0137);
            wr(AW'(32 + ((i * 5) % 32)), bufd[i]);
        end
        chk("R6 busy after fill", status, 8'h01);
        wr(6'd40, 16'h1234); wr(6'd41, 16'h5678);
        wait_free();
        f = model_prog(32, BUFW);
        chk("R6 buffer done", status, 8'h00);
        check_array("R6 R7 first region");

        // R8: next buffer lands at the next region
        for (int i = 0; i < BUFW; i++) begin
            bufd[i] = 16'h5A5A ^ 16'(i << 3);
            wr(AW'(63 - i), bufd[i]);
        end
        wait_free();
        f = model_prog(40, BUFW);
        chk("R8 second buffer", status, 8'h00);
        check_array("R8 region advance");

        // R9: outside non-exit write ignored, then partial commit on exit
        wr(6'd0, 16'h1111);
        chk("R9 outside ignored", status, 8'h00);
        for (int i = 0; i < 3; i++) begin
            bufd[i] = 16'h0F0F + 16'(i);
            wr(AW'(48 + i), bufd[i]);
        end
        wr(6'd0, 16'hFFFF);
        chk("R9 pending busy", status, 8'h01);
        wait_free();
        f = model_prog(48, 3);
        chk("R9 exit ready", status, 8'h80);
        check_array("R9 partial commit");

        // R9: exit with empty buffer
        wr(6'd0, 16'h0080); wr(6'd0, 16'h00D0);
        chk("R2 reopen", status, 8'h00);
        wr(6'd32, 16'hFFFF);
        chk("R9 empty exit", status, 8'h80);
        check_array("R9 nothing written");

        // R11: fill block 0 completely
        wr(6'd0, 16'h0080); wr(6'd0, 16'h00D0);
        for (int b = 0; b < BLKW / BUFW; b++) begin
            for (int i = 0; i < BUFW; i++) begin
                bufd[i] = 16'((b * BUFW + i) * 16'h0101) ^ 16'hFFF0;
                wr(AW'(b * BUFW + i), bufd[i]);
            end
            wait_free();
            f = model_prog(b * BUFW, BUFW);
            if (b < BLKW / BUFW - 1) chk("R8 block step", status, 8'h00);
            else                      chk("R11 block end", status, 8'h80);
        end
        check_array("R11 full block");

        // R10, R12: reprogram block 1 with a word that needs a 0->1 change
        wr(6'd32, 16'h0080); wr(6'd32, 16'h00D0);
        for (int i = 0; i < BUFW; i++) begin
            if (i == 5) bufd[i] = ~model[32 + i] | 16'h00FF;
            else        bufd[i] = model[32 + i] & 16'hF0F0;
            wr(AW'(32 + i), bufd[i]);
        end
        wait_free();
        f = model_prog(32, BUFW);
        chk("R10 verify fault", status, 8'h90);
        check_array("R12 AND programming");

        summary();
    end
endmodule